// File: doc/BRIEF.md
# Dual-Accumulator Saturating Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point signal-processing datapath. Each clock it can take two 16-bit operands and multiply them. Each operand is widened to 17 bits according to its own sign-mode bit, so signed, unsigned and mixed-sign products are all exact. In fractional mode the product is doubled to keep 1.15 × 1.15 operands aligned with a 1.31 result. The product then clears, adds to, subtracts from, or replaces one of two 40-bit accumulators, chosen by a select bit. The update is registered, so the new value appears after the next rising clock edge.

Each accumulator has its own saturation enable. A shared mode bit selects the clamp limits: the 1.31 range, or the full 40-bit range. Every accumulator reports an overflow flag that tracks its latest written value. It also keeps a sticky saturation flag that stays set until a clear strobe removes it. Combined overflow and saturation flags are the OR of the two lanes.

Operands arrive as a plain valid-qualified stream with no ready signal. The unit never stalls, so it accepts every cycle that has `op_valid` high. An upstream producer never sees back-pressure and may issue one operation per clock without gaps. Cycles with `op_valid` low are idle and change no accumulator.

Top module: `mac_dual_acc`

## Requirements
- R1: While reset is asserted, and right after it, both accumulators read zero and all six flags read zero.
- R2: Operand x is widened to 17 bits with zero fill when `x_unsigned`=1 and with sign fill when it is 0. Operand y is widened the same way under `y_unsigned`. The product is exact for signed, unsigned and mixed-sign pairs.
- R3: When `frac_mode`=1 the product is doubled. 0x8000 × 0x8000, both signed, then yields +0x0080000000 and does not wrap to a negative value.
- R4: `op_code` 2'b00 clears the accumulator, 2'b01 adds the product, 2'b10 subtracts the product, and 2'b11 loads the product. The target is A when `acc_sel`=0 and B when `acc_sel`=1. The result shows one clock after an `op_valid` cycle. The other accumulator is unchanged, and `op_valid`=0 changes neither accumulator.
- R5: With the target's saturation enable at 0, the exact result wraps modulo 2^40.
- R6: With saturation enabled and `super_sat`=0, the result is clamped to 0x007FFFFFFF above and to 0xFF80000000 below.
- R7: With saturation enabled and `super_sat`=1, the exact (41-bit) result is clamped to 0x7FFFFFFFFF above and to 0x8000000000 below.
- R8: A lane's overflow flag is updated on every write to that lane. It is 1 when bits 39:31 of the written value are not all equal and 0 otherwise. A lane that is not written keeps its flag.
- R9: A lane's sticky saturation flag is set by any write that is clamped. It stays set through later writes until a clear.
- R10: `ovf_any` is the OR of both overflow flags and `sat_any` is the OR of both sticky flags. A `clr_sat` pulse clears both sticky flags on the next clock, but a clamp in that same cycle keeps its own lane set.
- R11: The saturation enables are independent. A lane whose enable is 0 never clamps and never sets its sticky flag, whatever the other lane's enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 00 clear, 01 add product, 10 subtract product, 11 load product |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| x_unsigned | input | 1 | Treat x as unsigned |
| y_unsigned | input | 1 | Treat y as unsigned |
| frac_mode | input | 1 | Double the product (fractional alignment) |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| super_sat | input | 1 | 1 = clamp at 40-bit limits, 0 = clamp at 1.31 limits |
| clr_sat | input | 1 | Clear both sticky saturation flags |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | A's latest value is outside 1.31 |
| ovf_b | output | 1 | B's latest value is outside 1.31 |
| ovf_any | output | 1 | OR of both overflow flags |
| sat_a | output | 1 | Sticky: A has clamped |
| sat_b | output | 1 | Sticky: B has clamped |
| sat_any | output | 1 | OR of both sticky flags |

## Verification
The properties assume that the inputs are known and steady from the falling clock edge up to the rising edge that samples them. They also assume that `acc_sel` names a lane only when `op_valid` is high. Every stimulus change is therefore applied at a falling edge. The random stream draws operands from both the full range and the extremes 0x0000, 0x7FFF, 0x8000 and 0xFFFF, so that clamping in both directions and in both limit modes comes up often. Long directed chains of large fractional products reach the 40-bit limits, which random accumulation rarely gets near.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_CLR  = 2'b00,
    OP_MAC  = 2'b01,
    OP_MSC  = 2'b10,
    OP_LOAD = 2'b11
  } mac_op_e;

  localparam int unsigned N_LANES = 2;

endpackage

// File: rtl/mac_operand_ext.sv
module mac_operand_ext #(
  parameter int unsigned OPW = 16
) (
  input  logic [OPW-1:0] d,
  input  logic           uns,
  output logic [OPW:0]   q
);
  // one extra bit: sign copy for signed, zero for unsigned
  always_comb q = {(~uns) & d[OPW-1], d};
endmodule

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int unsigned OPW = 16,
  localparam int unsigned FW = 2 * (OPW + 1),
  localparam int unsigned PW = FW + 1
) (
  input  logic signed [OPW:0]  a,
  input  logic signed [OPW:0]  b,
  input  logic                 frac,
  output logic signed [PW-1:0] prod
);
  logic signed [FW-1:0] full;

  always_comb begin
    full = a * b;
    if (frac) prod = {full, 1'b0};
    else      prod = {full[FW-1], full};
  end
endmodule

// File: rtl/mac_lane.sv
module mac_lane
  import mac_pkg::*;
#(
  parameter int unsigned ACCW      = 40,
  parameter int unsigned PW        = 35,
  parameter int unsigned GUARD_LSB = 31,
  localparam int unsigned EW       = ACCW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           op,
  input  logic signed [PW-1:0] prod,
  input  logic                 sat_en,
  input  logic                 super_sat,
  input  logic                 clr_sat,
  output logic [ACCW-1:0]      acc,
  output logic                 ovf,
  output logic                 sat
);
  localparam logic [EW-1:0] HI_NORM = {{(EW-GUARD_LSB){1'b0}}, {GUARD_LSB{1'b1}}};
  localparam logic [EW-1:0] LO_NORM = {{(EW-GUARD_LSB){1'b1}}, {GUARD_LSB{1'b0}}};
  localparam logic [EW-1:0] HI_FULL = {2'b00, {(ACCW-1){1'b1}}};
  localparam logic [EW-1:0] LO_FULL = {2'b11, {(ACCW-1){1'b0}}};

  logic signed [EW-1:0] acc_ext, prod_ext, exact, hi_lim, lo_lim;
  logic [ACCW-1:0]      nxt;
  logic                 clamp, nxt_ovf;

  always_comb begin
    acc_ext  = {acc[ACCW-1], acc};
    prod_ext = {{(EW-PW){prod[PW-1]}}, prod};
    unique case (mac_op_e'(op))
      OP_CLR:  exact = '0;
      OP_MAC:  exact = acc_ext + prod_ext;
      OP_MSC:  exact = acc_ext - prod_ext;
      default: exact = prod_ext;
    endcase
  end

  always_comb begin
    hi_lim = super_sat ? HI_FULL : HI_NORM;
    lo_lim = super_sat ? LO_FULL : LO_NORM;
    clamp  = 1'b0;
    nxt    = exact[ACCW-1:0];
    if (sat_en) begin
      if (exact > hi_lim) begin
        nxt   = hi_lim[ACCW-1:0];
        clamp = 1'b1;
      end else if (exact < lo_lim) begin
        nxt   = lo_lim[ACCW-1:0];
        clamp = 1'b1;
      end
    end
    nxt_ovf = !((&nxt[ACCW-1:GUARD_LSB]) || !(|nxt[ACCW-1:GUARD_LSB]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (wr_en) begin
      acc <= nxt;
      ovf <= nxt_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sat <= 1'b0;
    else if (wr_en && clamp)   sat <= 1'b1;
    else if (clr_sat)          sat <= 1'b0;
  end
endmodule

// File: rtl/mac_dual_acc.sv
module mac_dual_acc
  import mac_pkg::*;
#(
  parameter int unsigned OPW       = 16,
  parameter int unsigned ACCW      = 40,
  parameter int unsigned GUARD_LSB = 31,
  localparam int unsigned PW       = 2 * (OPW + 1) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [1:0]      op_code,
  input  logic            acc_sel,
  input  logic [OPW-1:0]  x_in,
  input  logic [OPW-1:0]  y_in,
  input  logic            x_unsigned,
  input  logic            y_unsigned,
  input  logic            frac_mode,
  input  logic            sat_en_a,
  input  logic            sat_en_b,
  input  logic            super_sat,
  input  logic            clr_sat,
  output logic [ACCW-1:0] acc_a,
  output logic [ACCW-1:0] acc_b,
  output logic            ovf_a,
  output logic            ovf_b,
  output logic            ovf_any,
  output logic            sat_a,
  output logic            sat_b,
  output logic            sat_any
);
  logic [OPW:0]         x_w, y_w;
  logic signed [PW-1:0] prod;
  logic [N_LANES-1:0]   lane_sat_en, lane_ovf, lane_sat;
  logic [ACCW-1:0]      lane_acc [N_LANES];

  mac_operand_ext #(.OPW(OPW)) u_ext_x (.d(x_in), .uns(x_unsigned), .q(x_w));
  mac_operand_ext #(.OPW(OPW)) u_ext_y (.d(y_in), .uns(y_unsigned), .q(y_w));

  mac_mul #(.OPW(OPW)) u_mul (
    .a(x_w), .b(y_w), .frac(frac_mode), .prod(prod)
  );

  assign lane_sat_en = {sat_en_b, sat_en_a};

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    logic wr;
    assign wr = op_valid && (acc_sel == 1'(i));
    mac_lane #(.ACCW(ACCW), .PW(PW), .GUARD_LSB(GUARD_LSB)) u_lane (
      .clk(clk), .rst_n(rst_n), .wr_en(wr), .op(op_code), .prod(prod),
      .sat_en(lane_sat_en[i]), .super_sat(super_sat), .clr_sat(clr_sat),
      .acc(lane_acc[i]), .ovf(lane_ovf[i]), .sat(lane_sat[i])
    );
  end

  assign acc_a   = lane_acc[0];
  assign acc_b   = lane_acc[1];
  assign ovf_a   = lane_ovf[0];
  assign ovf_b   = lane_ovf[1];
  assign sat_a   = lane_sat[0];
  assign sat_b   = lane_sat[1];
  assign ovf_any = |lane_ovf;
  assign sat_any = |lane_sat;
endmodule

// File: rtl/mac_dual_acc_chk.sv
module mac_dual_acc_chk
  import mac_pkg::*;
#(
  parameter int unsigned OPW       = 16,
  parameter int unsigned ACCW      = 40,
  parameter int unsigned GUARD_LSB = 31
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [1:0]      op_code,
  input logic            acc_sel,
  input logic            sat_en_a,
  input logic            sat_en_b,
  input logic            super_sat,
  input logic            clr_sat,
  input logic [ACCW-1:0] acc_a,
  input logic [ACCW-1:0] acc_b,
  input logic            ovf_a,
  input logic            ovf_b,
  input logic            sat_a,
  input logic            sat_b,
  input logic            sat_any
);
  assert_clr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CLR && !acc_sel) |=> (acc_a == '0 && !ovf_a));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (acc_a == $past(acc_a) && acc_b == $past(acc_b)));

  assert_other_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc_sel) |=> (acc_b == $past(acc_b) && ovf_b == $past(ovf_b)));

  assert_norm_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc_sel && sat_en_a && !super_sat) |=>
      ((&acc_a[ACCW-1:GUARD_LSB]) || !(|acc_a[ACCW-1:GUARD_LSB])));

  assert_ovf_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_b == !((&acc_b[ACCW-1:GUARD_LSB]) || !(|acc_b[ACCW-1:GUARD_LSB])));

  assert_sat_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_a) |-> $past(op_valid && !acc_sel && sat_en_a));

  assert_sat_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sat && !op_valid) |=> !sat_any);

  assert_no_sat_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_b) |-> $past(sat_en_b));
endmodule

bind mac_dual_acc mac_dual_acc_chk #(.OPW(OPW), .ACCW(ACCW), .GUARD_LSB(GUARD_LSB)) u_chk (.*);

// File: tb/mac_dual_acc_test.sv
module mac_dual_acc_test;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, acc_sel, x_unsigned, y_unsigned, frac_mode;
  logic [1:0]  op_code;
  logic [15:0] x_in, y_in;
  logic        sat_en_a, sat_en_b, super_sat, clr_sat;
  logic [39:0] acc_a, acc_b;
  logic        ovf_a, ovf_b, ovf_any, sat_a, sat_b, sat_any;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [39:0] m_acc [2];
  bit          m_ovf [2];
  bit          m_sat [2];

  always #(CLK_P/2) clk = ~clk;

  mac_dual_acc uut (.*);

  function automatic longint mprod(logic [15:0] x, logic [15:0] y, bit xu, bit yu, bit fr);
    longint xa, ya, p;
    xa = xu ? longint'({48'd0, x}) : longint'($signed(x));
    ya = yu ? longint'({48'd0, y}) : longint'($signed(y));
    p  = xa * ya;
    return fr ? p * 2 : p;
  endfunction

  task automatic model(bit v, logic [1:0] op, bit sel, longint p, bit sea, bit seb, bit sup, bit clr);
    for (int i = 0; i < 2; i++) begin
      bit clamp = 0;
      if (v && sel == i[0]) begin
        longint a, e, hi, lo;
        bit se = (i == 0) ? sea : seb;
        a  = longint'($signed(m_acc[i]));
        case (op)
          2'b00: e = 0;
          2'b01: e = a + p;
          2'b10: e = a - p;
          default: e = p;
        endcase
        hi = sup ? (64'sd1 <<< 39) - 1 : (64'sd1 <<< 31) - 1;
        lo = sup ? -(64'sd1 <<< 39) : -(64'sd1 <<< 31);
        if (se && e > hi) begin e = hi; clamp = 1; end
        else if (se && e < lo) begin e = lo; clamp = 1; end
        m_acc[i] = e[39:0];
        m_ovf[i] = !((&m_acc[i][39:31]) || !(|m_acc[i][39:31]));
      end
      if (clamp) m_sat[i] = 1;
      else if (clr) m_sat[i] = 0;
    end
  endtask

  task automatic check_state(string tag);
    logic [5:0] got, exp;
    got = {ovf_a, ovf_b, ovf_any, sat_a, sat_b, sat_any};
    exp = {m_ovf[0], m_ovf[1], m_ovf[0] | m_ovf[1], m_sat[0], m_sat[1], m_sat[0] | m_sat[1]};
    tests++;
    if (acc_a !== m_acc[0] || acc_b !== m_acc[1] || got !== exp) begin
      fails++;
      $display("FAIL %s: acc_a=%h acc_b=%h flags=%b expected acc_a=%h acc_b=%h flags=%b",
               tag, acc_a, acc_b, got, m_acc[0], m_acc[1], exp);
    end
  endtask

  task automatic expect_val(logic [39:0] got, logic [39:0] exp, string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(bit v, logic [1:0] op, bit sel, logic [15:0] x, logic [15:0] y,
                        bit xu, bit yu, bit fr, bit sea, bit seb, bit sup, bit clr, string tag);
    op_valid = v; op_code = op; acc_sel = sel; x_in = x; y_in = y;
    x_unsigned = xu; y_unsigned = yu; frac_mode = fr;
    sat_en_a = sea; sat_en_b = seb; super_sat = sup; clr_sat = clr;
    model(v, op, sel, mprod(x, y, xu, yu, fr), sea, seb, sup, clr);
    @(negedge clk);
    op_valid = 0; clr_sat = 0;
    check_state(tag);
  endtask

  function automatic logic [15:0] pick();
    case ($urandom_range(0, 5))
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_ovf[i] = 0; m_sat[i] = 0; end
    rst_n = 0; op_valid = 0; op_code = 0; acc_sel = 0; x_in = 0; y_in = 0;
    x_unsigned = 0; y_unsigned = 0; frac_mode = 0;
    sat_en_a = 0; sat_en_b = 0; super_sat = 0; clr_sat = 0;
    repeat (3) @(negedge clk);
    check_state("R1 during reset");
    rst_n = 1;
    @(negedge clk);
    check_state("R1 after reset");

    // R2: signed, unsigned, mixed
    run_op(1, 2'b11, 0, 16'd3, 16'hFFFB, 0, 0, 0, 0, 0, 0, 0, "R2 signed load");
    expect_val(acc_a, 40'hFFFFFFFFF1, "R2 3*-5");
    run_op(1, 2'b11, 1, 16'hFFFF, 16'hFFFF, 1, 1, 0, 0, 0, 0, 0, "R2 unsigned load R8");
    expect_val(acc_b, 40'h00FFFE0001, "R2 unsigned max");
    run_op(1, 2'b11, 0, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 0, 0, 0, "R2 mixed load");
    expect_val(acc_a, 40'hFFFFFF0001, "R2 65535*-1");

    // R3 fractional -1 * -1, then clamped under R6
    run_op(1, 2'b11, 0, 16'h8000, 16'h8000, 0, 0, 1, 0, 0, 0, 0, "R3 frac -1*-1");
    expect_val(acc_a, 40'h0080000000, "R3 no wrap");
    run_op(1, 2'b11, 0, 16'h8000, 16'h8000, 0, 0, 1, 1, 0, 0, 0, "R6 clamp high R9");
    expect_val(acc_a, 40'h007FFFFFFF, "R6 high limit");
    run_op(0, 2'b00, 0, 16'h1234, 16'h5678, 1, 0, 1, 1, 1, 1, 0, "R9 sticky holds on idle");
    run_op(1, 2'b11, 0, 16'd2, 16'd2, 0, 0, 0, 1, 0, 0, 0, "R9 sticky across clean write");
    run_op(0, 2'b00, 0, 16'd0, 16'd0, 0, 0, 0, 0, 0, 0, 1, "R10 clear sticky");

    // R4 operations
    run_op(1, 2'b11, 0, 16'd100, 16'd100, 0, 0, 0, 0, 0, 0, 0, "R4 load");
    run_op(1, 2'b10, 0, 16'd30, 16'd30, 0, 0, 0, 0, 0, 0, 0, "R4 subtract");
    expect_val(acc_a, 40'd9100, "R4 10000-900");
    run_op(1, 2'b01, 0, 16'd5, 16'd5, 0, 0, 0, 0, 0, 0, 0, "R4 add");
    expect_val(acc_a, 40'd9125, "R4 9100+25");
    run_op(1, 2'b00, 1, 16'd7, 16'd7, 0, 0, 0, 0, 0, 0, 0, "R4 clear B R8 ovf drops");
    run_op(0, 2'b11, 0, 16'hFFFF, 16'hFFFF, 1, 1, 1, 0, 0, 0, 0, "R4 idle ignored");

    // R6 low limit
    run_op(1, 2'b11, 0, 16'h8000, 16'h7FFF, 0, 0, 1, 1, 0, 0, 0, "R6 near low");
    run_op(1, 2'b10, 0, 16'h7FFF, 16'h7FFF, 0, 0, 1, 1, 0, 0, 0, "R6 clamp low");
    expect_val(acc_a, 40'hFF80000000, "R6 low limit");

    // R10 clamp wins over clear in the same cycle; other lane still cleared
    run_op(1, 2'b11, 1, 16'h8000, 16'h8000, 0, 0, 1, 0, 1, 0, 0, "R10 set B");
    run_op(1, 2'b11, 0, 16'h8000, 16'h8000, 0, 0, 1, 1, 0, 0, 1, "R10 set wins on A, B cleared");

    // R11: A enabled, B disabled; B overflows without clamping
    run_op(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 clear");
    run_op(1, 2'b11, 1, 16'h8000, 16'h8000, 0, 0, 1, 1, 0, 0, 0, "R11 B unclamped");
    expect_val(acc_b, 40'h0080000000, "R11 B value");

    // R7: super-saturation chain on A
    run_op(1, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 clear A");
    for (int k = 0; k < 70; k++)
      run_op(1, 2'b01, 0, 16'hFFFF, 16'hFFFF, 1, 1, 1, 1, 0, 1, 0, "R7 super chain");
    expect_val(acc_a, 40'h7FFFFFFFFF, "R7 high limit");
    for (int k = 0; k < 140; k++)
      run_op(1, 2'b10, 0, 16'hFFFF, 16'hFFFF, 1, 1, 1, 1, 0, 1, 0, "R7 super chain down");
    expect_val(acc_a, 40'h8000000000, "R7 low limit");

    // R5: wrap chain on B without saturation
    run_op(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 clear B");
    for (int k = 0; k < 70; k++)
      run_op(1, 2'b01, 1, 16'hFFFF, 16'hFFFF, 1, 1, 1, 0, 0, 1, 0, "R5 wrap chain");

    // random mix
    for (int k = 0; k < 600; k++) begin
      run_op($urandom_range(0, 9) != 0, 2'($urandom), 1'($urandom), pick(), pick(),
             1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 3) != 0,
             $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
             $urandom_range(0, 9) == 0, "R2 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule